// File: doc/BRIEF.md
# SPI Host Serial Clock and Timing Generator

This block produces the serial clock, the active-low chip select and the bit timing for one 8-bit SPI host transfer. Software programs a 32-bit configuration word that holds four fields: a clock divider, a lead delay, a clock polarity bit and a clock phase bit. A one-cycle `start` pulse then runs one full transfer. Chip select goes active, the lead delay passes, sixteen serial clock edges follow, and the block sends `tx_data` and receives `rx_data`, most significant bit first. At the end it releases chip select and raises a `done` pulse.

The control is a four-state machine. `ST_IDLE` waits for `start`. The transition IDLE→LEAD loads the transmit byte and asserts chip select. `ST_LEAD` counts the lead delay, and LEAD→CLOCK makes serial clock edge 1. `ST_CLOCK` makes edges 2 to 16, one every half period. CLOCK→TRAIL follows edge 16. `ST_TRAIL` waits one more half period, and TRAIL→IDLE releases chip select and pulses `done`. One down-counter times the lead, every half period and the trail.

The half period is BAUD+1 system clock cycles. A lead field of N>0 gives N cycles from chip select to the first edge. A lead field of zero gives half a serial clock period.

Top module: `spi_host_timing`

## Requirements
- R1: After reset the configuration word reads 0. Its fields are: lead delay in bits 23:16, divider (BAUD) in bits 15:8, phase (CPHA) in bit 1 and polarity (CPOL) in bit 0. All other bits read as 0, so writing 32'hFFFFFFFF while idle reads back 32'h00FFFF03.
- R2: With a nonzero lead field N, the first serial clock edge comes exactly N system clock cycles after chip select goes low.
- R3: With a lead field of 0, the first serial clock edge comes BAUD+1 cycles (half a serial clock period) after chip select goes low.
- R4: While no transfer runs, `sck` equals CPOL: low for CPOL=0 and high for CPOL=1.
- R5: A transfer has exactly 16 serial clock edges, spaced exactly BAUD+1 system clock cycles apart.
- R6: With CPHA=0, `mosi` carries bit 7 of `tx_data` from the cycle chip select goes low. `miso` is sampled on odd (leading) edges, and `mosi` changes on even (trailing) edges.
- R7: With CPHA=1, `mosi` changes on odd (leading) edges, starting with bit 7, and `miso` is sampled on even (trailing) edges.
- R8: Data moves most significant bit first in both directions. When `done` pulses, `rx_data` holds the 8 sampled `miso` bits, with the first sample in bit 7.
- R9: `busy` is high from the cycle after an accepted `start` until chip select is released. Chip select goes high BAUD+1 cycles after edge 16. `done` is high for exactly that one cycle.
- R10: A configuration write is ignored while `busy` is high or in the same cycle as an accepted `start`.
- R11: A `start` pulse while `busy` is high is ignored. The running transfer keeps its data, and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| start | input | 1 | One-cycle transfer request |
| tx_data | input | 8 | Byte to send, taken with `start` |
| miso | input | 1 | Serial data from the device |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the device |
| rx_data | output | 8 | Received byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
A table of transfers covers all four CPOL/CPHA combinations. It pairs lead values of zero, small and maximum with several divider values, so a lead of zero is told apart from a lead of N. The data bytes are alternating, single-edge-bit, all-ones and all-zeros patterns. These show bit order, a stuck line and which edge launches or samples data. A model of the device shifts `miso` on the opposite edge and records `mosi` on the sample edge, so a wrong phase corrupts both received bytes. Directed runs cover the reset value, masking of unused bits, a write during a transfer and a second `start` during a transfer.

// File: rtl/spi_tg_pkg.sv
package spi_tg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_CLOCK,
        ST_TRAIL
    } tg_state_e;

endpackage

// File: rtl/spi_tg_cfg.sv
module spi_tg_cfg #(
    parameter int REG_W  = 32,
    parameter int DIV_W  = 8,
    parameter int LEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              lock,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [DIV_W-1:0]  div,
    output logic [LEAD_W-1:0] lead,
    output logic              cpha,
    output logic              cpol
);
    localparam int DIV_LSB  = 8;
    localparam int LEAD_LSB = DIV_LSB + DIV_W;
    localparam logic [REG_W-1:0] FIELD_MASK =
        (((REG_W)'(1) << LEAD_W) - 1) << LEAD_LSB |
        (((REG_W)'(1) << DIV_W) - 1) << DIV_LSB |
        (REG_W)'(3);

    logic [REG_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (wr_en && !lock) begin
            word_q <= wdata & FIELD_MASK;
        end
    end

    assign rdata = word_q;
    assign div   = word_q[DIV_LSB +: DIV_W];
    assign lead  = word_q[LEAD_LSB +: LEAD_W];
    assign cpha  = word_q[1];
    assign cpol  = word_q[0];

endmodule

// File: rtl/spi_tg_timer.sv
module spi_tg_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/spi_tg_shift.sv
module spi_tg_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              cpha,
    input  logic              launch,
    input  logic              capture,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_data
);
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic              mosi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q   <= '0;
            mosi_q <= 1'b0;
        end else if (load) begin
            if (!cpha) begin
                // phase 0: first bit must already be on the line
                mosi_q <= tx_data[DATA_W-1];
                tx_q   <= {tx_data[DATA_W-2:0], 1'b0};
            end else begin
                tx_q   <= tx_data;
            end
        end else if (launch) begin
            mosi_q <= tx_q[DATA_W-1];
            tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (capture) begin
            rx_q <= {rx_q[DATA_W-2:0], miso};
        end
    end

    assign mosi    = mosi_q;
    assign rx_data = rx_q;

endmodule

// File: rtl/spi_host_timing.sv
module spi_host_timing
    import spi_tg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8,
    parameter int LEAD_W = 8,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              miso,
    output logic              sck,
    output logic              cs_n,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_data,
    output logic              busy,
    output logic              done
);
    localparam int EDGES  = 2 * DATA_W;
    localparam int ECNT_W = $clog2(EDGES + 1);
    localparam int TMR_W  = (DIV_W > LEAD_W) ? DIV_W : LEAD_W;

    tg_state_e state_q, state_nx;

    logic [DIV_W-1:0]  div;
    logic [LEAD_W-1:0] lead;
    logic              cpha, cpol;

    logic              tmr_load, tmr_zero;
    logic [TMR_W-1:0]  tmr_val;
    logic              accept, toggle, finish;
    logic              leading, last_edge;
    logic              launch, capture;

    logic              cs_n_q, done_q, phase_q;
    logic [ECNT_W-1:0] edge_q;

    spi_tg_cfg #(.REG_W(REG_W), .DIV_W(DIV_W), .LEAD_W(LEAD_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_we),
        .lock  (busy || start),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .div   (div),
        .lead  (lead),
        .cpha  (cpha),
        .cpol  (cpol)
    );

    spi_tg_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    spi_tg_shift #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .cpha    (cpha),
        .launch  (launch),
        .capture (capture),
        .tx_data (tx_data),
        .miso    (miso),
        .mosi    (mosi),
        .rx_data (rx_data)
    );

    // edge number about to be made is edge_q+1; odd numbers are leading edges
    assign leading   = ~edge_q[0];
    assign last_edge = (edge_q == ECNT_W'(EDGES - 1));

    always_comb begin
        state_nx = state_q;
        tmr_load = 1'b0;
        tmr_val  = TMR_W'(div);
        accept   = 1'b0;
        toggle   = 1'b0;
        finish   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = (lead == '0) ? TMR_W'(div)
                                            : TMR_W'(lead) - TMR_W'(1);
                    state_nx = ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (tmr_zero) begin
                    toggle   = 1'b1;
                    tmr_load = 1'b1;
                    state_nx = ST_CLOCK;
                end
            end
            ST_CLOCK: begin
                if (tmr_zero) begin
                    toggle   = 1'b1;
                    tmr_load = 1'b1;
                    if (last_edge) begin
                        state_nx = ST_TRAIL;
                    end
                end
            end
            ST_TRAIL: begin
                if (tmr_zero) begin
                    finish   = 1'b1;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign launch  = toggle && (cpha ? leading : (!leading && !last_edge));
    assign capture = toggle && (cpha ? !leading : leading);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q  <= 1'b1;
            done_q  <= 1'b0;
            phase_q <= 1'b0;
            edge_q  <= '0;
        end else begin
            done_q <= finish;
            if (accept) begin
                cs_n_q <= 1'b0;
                edge_q <= '0;
            end else if (finish) begin
                cs_n_q <= 1'b1;
            end
            if (toggle) begin
                phase_q <= ~phase_q;
                edge_q  <= edge_q + ECNT_W'(1);
            end
        end
    end

    assign sck  = phase_q ^ cpol;
    assign cs_n = cs_n_q;
    assign done = done_q;
    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/spi_host_timing_chk.sv
module spi_host_timing_chk #(
    parameter int DATA_W = 8,
    parameter int REG_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [DATA_W-1:0] tx_data,
    input logic [REG_W-1:0]  cfg_rdata,
    input logic              busy,
    input logic              done,
    input logic              sck,
    input logic              cs_n,
    input logic              mosi
);
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !busy));

    a_r9_cs_rise_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> done);

    a_r9_busy_cs: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cs_n);

    a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sck == cfg_rdata[0]));

    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_rdata));

    a_r6_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && !cfg_rdata[1]) |-> (mosi == $past(tx_data[DATA_W-1])));

    a_r11_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> (busy || done));

endmodule

bind spi_host_timing spi_host_timing_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tx_data   (tx_data),
    .cfg_rdata (cfg_rdata),
    .busy      (busy),
    .done      (done),
    .sck       (sck),
    .cs_n      (cs_n),
    .mosi      (mosi)
);

// File: tb/spi_host_timing_tb_top.sv
module spi_host_timing_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        start = 1'b0;
    logic [7:0]  tx_data = '0;
    logic        miso = 1'b0;
    logic        sck, cs_n, mosi, busy, done;
    logic [7:0]  rx_data;

    always #10 clk = ~clk;

    spi_host_timing dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .start     (start),
        .tx_data   (tx_data),
        .miso      (miso),
        .sck       (sck),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .rx_data   (rx_data),
        .busy      (busy),
        .done      (done)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // device model and timing monitor
    int         cyc = 0;
    int         t_cs = 0, t_last = 0;
    int         n_edges = 0, lead_m = 0, trail_m = 0;
    int         hmin = 0, hmax = 0;
    int         done_cnt = 0;
    int         s_idx = 0;
    bit         done_at_rise = 0;
    bit         cur_cpha = 0;
    logic       mosi_at_cs = 0;
    logic [7:0] s_byte = '0;
    logic [7:0] got = '0;
    logic       prev_sck = 0, prev_cs = 1;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_cs && !cs_n) begin
                t_cs = cyc;
                n_edges = 0;
                hmin = 1000000;
                hmax = 0;
                got = '0;
                mosi_at_cs = mosi;
                if (!cur_cpha) begin
                    miso = s_byte[7];
                    s_idx = 6;
                end else begin
                    s_idx = 7;
                end
            end else if (!cs_n && sck != prev_sck) begin
                n_edges++;
                if (n_edges == 1) begin
                    lead_m = cyc - t_cs;
                end else begin
                    if (cyc - t_last < hmin) hmin = cyc - t_last;
                    if (cyc - t_last > hmax) hmax = cyc - t_last;
                end
                t_last = cyc;
                if (cur_cpha ? (n_edges % 2 == 0) : (n_edges % 2 == 1)) begin
                    got = {got[6:0], mosi};
                end else if (s_idx >= 0) begin
                    miso = s_byte[s_idx];
                    s_idx--;
                end
            end
            if (!prev_cs && cs_n) begin
                trail_m = cyc - t_last;
                done_at_rise = done;
            end
            if (done) done_cnt++;
        end
        prev_sck = sck;
        prev_cs = cs_n;
    end

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // extra: 0 none, 1 start while busy, 2 cfg write while busy
    task automatic do_xfer(input logic [7:0] tx, input logic [7:0] sb,
                           input int extra, input logic [31:0] extra_w);
        int w;
        logic [31:0] cfg_before;
        cfg_before = cfg_rdata;
        cur_cpha = cfg_rdata[1];
        s_byte = sb;
        @(negedge clk);
        tx_data = tx;
        start = 1'b1;
        done_cnt = 0;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 busy after start", busy, 1);
        if (extra != 0) begin
            repeat (2) @(negedge clk);
            if (extra == 1) begin
                tx_data = ~tx;
                start = 1'b1;
            end else begin
                cfg_we = 1'b1;
                cfg_wdata = extra_w;
            end
            @(negedge clk);
            start = 1'b0;
            cfg_we = 1'b0;
            if (extra == 2)
                chk(cfg_rdata == cfg_before, "R10 write while busy", cfg_rdata, cfg_before);
        end
        w = 0;
        while (done_cnt == 0 && w < 20000) begin
            @(negedge clk);
            w++;
        end
        chk(done_cnt != 0, "R9 transfer completes", done_cnt, 1);
        repeat (4) @(negedge clk);
    endtask

    localparam int NV = 6;
    // {lead[7:0], baud[7:0], cpha, cpol, tx[7:0], device byte[7:0]}
    localparam logic [33:0] VEC [NV] = '{
        {8'd0,   8'd0, 1'b0, 1'b0, 8'hA5, 8'h3C},
        {8'd3,   8'd1, 1'b0, 1'b1, 8'h81, 8'h7E},
        {8'd0,   8'd2, 1'b1, 1'b0, 8'h5A, 8'hC3},
        {8'd7,   8'd0, 1'b1, 1'b1, 8'hFF, 8'h00},
        {8'd1,   8'd4, 1'b0, 1'b0, 8'h00, 8'hFF},
        {8'd255, 8'd3, 1'b1, 1'b1, 8'h96, 8'h69}
    };

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(cfg_rdata == 32'h0, "R1 reset cfg", cfg_rdata, 0);
        chk(cs_n == 1'b1, "R1 reset cs_n", cs_n, 1);
        chk(sck == 1'b0, "R4 reset sck", sck, 0);
        chk(busy == 1'b0 && done == 1'b0, "R9 reset busy/done", {busy, done}, 0);

        // R1 unused bits masked
        write_cfg(32'hFFFF_FFFF);
        chk(cfg_rdata == 32'h00FF_FF03, "R1 field mask", cfg_rdata, 32'h00FF_FF03);

        for (int i = 0; i < NV; i++) begin
            logic [7:0] lead_f, baud_f, txb, sb;
            bit cpha_f, cpol_f;
            int lead_e, half_e;
            {lead_f, baud_f, cpha_f, cpol_f, txb, sb} = VEC[i];
            half_e = int'(baud_f) + 1;
            lead_e = (lead_f == 0) ? half_e : int'(lead_f);
            write_cfg({8'h00, lead_f, baud_f, 6'b0, cpha_f, cpol_f});
            chk(sck == cpol_f, "R4 idle sck", sck, cpol_f);
            do_xfer(txb, sb, 0, 32'h0);
            if (lead_f == 0)
                chk(lead_m == lead_e, "R3 zero lead", lead_m, lead_e);
            else
                chk(lead_m == lead_e, "R2 lead delay", lead_m, lead_e);
            chk(n_edges == 16, "R5 edge count", n_edges, 16);
            chk(hmin == half_e && hmax == half_e, "R5 half period", hmax, half_e);
            if (!cpha_f) begin
                chk(mosi_at_cs == txb[7], "R6 first bit at cs", mosi_at_cs, txb[7]);
                chk(got == txb, "R6 R8 mosi byte", got, txb);
                chk(rx_data == sb, "R6 R8 rx byte", rx_data, sb);
            end else begin
                chk(got == txb, "R7 R8 mosi byte", got, txb);
                chk(rx_data == sb, "R7 R8 rx byte", rx_data, sb);
            end
            chk(trail_m == half_e, "R9 cs release delay", trail_m, half_e);
            chk(done_at_rise == 1'b1, "R9 done with cs rise", done_at_rise, 1);
            chk(done_cnt == 1, "R9 done one cycle", done_cnt, 1);
            chk(sck == cpol_f, "R4 sck after transfer", sck, cpol_f);
        end

        // R10 write while busy ignored
        write_cfg(32'h0002_0100);
        do_xfer(8'hC9, 8'h35, 2, 32'h00FF_FF03);
        chk(cfg_rdata == 32'h0002_0100, "R10 cfg kept", cfg_rdata, 32'h0002_0100);
        chk(got == 8'hC9, "R10 data unaffected", got, 8'hC9);

        // R11 start while busy ignored
        do_xfer(8'h3A, 8'h5C, 1, 32'h0);
        chk(got == 8'h3A, "R11 data kept", got, 8'h3A);
        chk(rx_data == 8'h5C, "R11 rx kept", rx_data, 8'h5C);
        repeat (20) @(negedge clk);
        chk(done_cnt == 1, "R11 no second transfer", done_cnt, 1);
        chk(busy == 1'b0 && cs_n == 1'b1, "R11 idle after", {busy, cs_n}, 1);

        // R10 write in same cycle as start ignored
        @(negedge clk);
        tx_data = 8'h11;
        start = 1'b1;
        cfg_we = 1'b1;
        cfg_wdata = 32'h0000_0003;
        done_cnt = 0;
        @(negedge clk);
        start = 1'b0;
        cfg_we = 1'b0;
        chk(cfg_rdata == 32'h0002_0100, "R10 write with start", cfg_rdata, 32'h0002_0100);
        while (done_cnt == 0) @(negedge clk);
        repeat (4) @(negedge clk);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule